// File: doc/BRIEF.md
# Programmable Modulator Clock Generator

This block derives the timing enables of a digital modulator from a single master clock. A down-counting divider, loaded from a register input, marks the filter sample instants. A phase sequencer then derives from these a symbol strobe on every fourth sample and a bit clock that changes level on every sample. The bit clock therefore runs at twice the symbol rate, whatever the modulation format. A second, small divider produces an auxiliary output clock with a near-even duty cycle.

A clock-enable input freezes all modulator timing. The auxiliary clock keeps running while the enable is low. In external-data-clock mode, each rise of the clock enable arms a resynchronizer. The modulator timing then holds, with the bit clock low, until the first rising edge of an external data clock. That edge restarts the sample period, the symbol phase and the bit clock together.

Top module: `mod_clkgen`

## Requirements
- R1: With the enable high, `samp_en` is a one-cycle pulse that repeats every n+1 enabled master cycles, where n is the effective value of `samp_div`.
- R2: `aux_clk` has a period of m+1 master cycles, where m is the effective value of `aux_div`. Its high phase lasts (m+2)/2 cycles, rounded down, so an odd period has its extra cycle in the high phase.
- R3: `sym_en` pulses only together with `samp_en`, on every fourth sample pulse. The first sample pulse after reset or after a resynchronization is a symbol pulse.
- R4: `bit_clk` changes level on every `samp_en` pulse, so its period is two samples, or half a symbol. It rises only in a cycle that carries a `samp_en` pulse.
- R5: While `clk_en` is low, no `samp_en` or `sym_en` pulse appears, the sample divider and `bit_clk` hold their state, and `aux_clk` keeps running.
- R6: A `samp_div` value below 4 behaves as 4. An `aux_div` value below 2 behaves as 2.
- R7: A new `samp_div` or `aux_div` value is taken only when its divider wraps, so the period in progress completes unchanged.
- R8: With `ext_mode` high, a rise of `clk_en` arms the resynchronizer. While armed, no sample pulses occur and `bit_clk` is driven low. In the first enabled cycle after arming in which `ext_dclk` is high after being low, `samp_en`, `sym_en` and `bit_clk` all go high together, and the sample period restarts from that cycle.
- R9: Reset is synchronous and active high. It clears the counters, drives `bit_clk`, `samp_en` and `sym_en` low, and sets `aux_clk` high at the start of its period. The first enabled cycle after reset produces a sample pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Gates all modulator timing except the auxiliary clock |
| ext_mode | input | 1 | Selects resynchronization to the external data clock |
| ext_dclk | input | 1 | External data clock, synchronous to `clk` |
| samp_div | input | 8 | Sample divider value n (period n+1) |
| aux_div | input | 4 | Auxiliary divider value m (period m+1) |
| samp_en | output | 1 | Filter sample-rate strobe |
| sym_en | output | 1 | Symbol strobe |
| bit_clk | output | 1 | Bit clock at twice the symbol rate |
| aux_clk | output | 1 | Free-running auxiliary clock |

## Verification
The bench builds the block with its default parameters: an 8-bit sample divider with a floor of 4, a 4-bit auxiliary divider with a floor of 2, and four samples per symbol. Because the random phase keeps `samp_div` small, the sample divider wraps many times within a few thousand cycles. This brings within reach the clamped values, divider changes landing mid-period, enable gaps at any symbol phase and resynchronization edges at any point of the sample period. The auxiliary divider runs over its full 0 to 15 range, so both odd and even periods and the clamp are exercised.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    localparam int SDIV_W_DEF       = 8;
    localparam int SDIV_MIN_DEF     = 4;
    localparam int ADIV_W_DEF       = 4;
    localparam int ADIV_MIN_DEF     = 2;
    localparam int SAMP_PER_SYM_DEF = 4;

    typedef struct packed {
        logic samp;
        logic sym;
        logic bitc;
    } mcg_timing_t;

    // Raise a divider value to its legal floor.
    function automatic int clamp_floor(input int value, input int floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

    // Length of the high phase for a divider value m (period m+1).
    function automatic int high_len(input int m);
        return (m + 2) / 2;
    endfunction

endpackage

// File: rtl/mcg_rate_div.sv
module mcg_rate_div #(
    parameter int W   = mcg_pkg::SDIV_W_DEF,
    parameter int MIN = mcg_pkg::SDIV_MIN_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    localparam logic [W-1:0] FLOOR = W'(MIN);

    logic [W-1:0] cnt;
    logic [W-1:0] div_eff;

    always_comb div_eff = (div < FLOOR) ? FLOOR : div;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= div_eff;
        end else if (en) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mcg_phase_seq.sv
module mcg_phase_seq
    import mcg_pkg::*;
#(
    parameter int SPS = mcg_pkg::SAMP_PER_SYM_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        restart,
    input  logic        hold_low,
    output mcg_timing_t tim
);
    localparam int QW  = (SPS > 2) ? $clog2(SPS) : 1;
    localparam int TGL = (SPS >= 4) ? SPS / 4 : 1;
    localparam logic [QW-1:0] QLAST = QW'(SPS - 1);
    localparam logic [QW-1:0] QONE  = QW'(1);

    logic [QW-1:0] q;
    logic          tgl_ok;

    always_comb tgl_ok = ((32'(q) % TGL) == 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            tim <= '0;
        end else begin
            tim.samp <= 1'b0;
            tim.sym  <= 1'b0;
            if (restart) begin
                tim.samp <= 1'b1;
                tim.sym  <= 1'b1;
                tim.bitc <= 1'b1;
                q        <= QONE;
            end else if (hold_low) begin
                tim.bitc <= 1'b0;
            end else if (tick) begin
                tim.samp <= 1'b1;
                tim.sym  <= (q == '0);
                if (tgl_ok) begin
                    tim.bitc <= ~tim.bitc;
                end
                q <= (q == QLAST) ? '0 : q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcg_aux_div.sv
module mcg_aux_div #(
    parameter int W   = mcg_pkg::ADIV_W_DEF,
    parameter int MIN = mcg_pkg::ADIV_MIN_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div,
    output logic         aux_clk
);
    localparam logic [W-1:0] FLOOR = W'(MIN);

    logic [W-1:0] pos, lim, div_eff, pos_n, lim_n;
    logic [W:0]   hi;
    logic         wrap;

    always_comb begin
        div_eff = (div < FLOOR) ? FLOOR : div;
        wrap    = (pos == lim);
        pos_n   = wrap ? '0 : pos + 1'b1;
        lim_n   = wrap ? div_eff : lim;
        hi      = ({1'b0, lim_n} + (W+1)'(2)) >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            lim     <= div_eff;
            aux_clk <= 1'b1;
        end else begin
            pos     <= pos_n;
            lim     <= lim_n;
            aux_clk <= ({1'b0, pos_n} < hi);
        end
    end
endmodule

// File: rtl/mcg_resync.sv
module mcg_resync (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic clk_en,
    input  logic ext_dclk,
    output logic armed,
    output logic restart
);
    logic en_q, d_q, rise, arm_set;

    always_comb begin
        rise    = ext_dclk && !d_q;
        arm_set = ext_mode && clk_en && !en_q;
        restart = armed && clk_en && rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            d_q   <= 1'b0;
            armed <= 1'b0;
        end else begin
            en_q <= clk_en;
            d_q  <= ext_dclk;
            if (arm_set) begin
                armed <= 1'b1;
            end else if (restart) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mod_clkgen.sv
module mod_clkgen
    import mcg_pkg::*;
#(
    parameter int SDIV_W       = mcg_pkg::SDIV_W_DEF,
    parameter int SDIV_MIN     = mcg_pkg::SDIV_MIN_DEF,
    parameter int ADIV_W       = mcg_pkg::ADIV_W_DEF,
    parameter int ADIV_MIN     = mcg_pkg::ADIV_MIN_DEF,
    parameter int SAMP_PER_SYM = mcg_pkg::SAMP_PER_SYM_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              ext_mode,
    input  logic              ext_dclk,
    input  logic [SDIV_W-1:0] samp_div,
    input  logic [ADIV_W-1:0] aux_div,
    output logic              samp_en,
    output logic              sym_en,
    output logic              bit_clk,
    output logic              aux_clk
);
    logic        armed, restart, tick, div_en;
    mcg_timing_t tim;

    assign div_en = clk_en && !armed;

    mcg_resync u_resync (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .clk_en   (clk_en),
        .ext_dclk (ext_dclk),
        .armed    (armed),
        .restart  (restart)
    );

    mcg_rate_div #(.W(SDIV_W), .MIN(SDIV_MIN)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .en      (div_en),
        .restart (restart),
        .div     (samp_div),
        .tick    (tick)
    );

    mcg_phase_seq #(.SPS(SAMP_PER_SYM)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .restart  (restart),
        .hold_low (armed),
        .tim      (tim)
    );

    mcg_aux_div #(.W(ADIV_W), .MIN(ADIV_MIN)) u_aux (
        .clk     (clk),
        .rst     (rst),
        .div     (aux_div),
        .aux_clk (aux_clk)
    );

    assign samp_en = tim.samp;
    assign sym_en  = tim.sym;
    assign bit_clk = tim.bitc;
endmodule

// File: rtl/mcg_checker.sv
module mcg_checker #(
    parameter int ADIV_W = mcg_pkg::ADIV_W_DEF
) (
    input logic clk,
    input logic rst,
    input logic clk_en,
    input logic samp_en,
    input logic sym_en,
    input logic bit_clk,
    input logic aux_clk
);
    localparam int MAXHI = mcg_pkg::high_len((1 << ADIV_W) - 1);
    localparam int RW    = ADIV_W + 2;

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (!aux_clk) begin
            hi_run <= '0;
        end else if (hi_run != {RW{1'b1}}) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    assert_sym_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
        sym_en |-> samp_en);

    assert_gate_blocks_sample_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(clk_en) |-> !samp_en);

    assert_bit_rise_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(bit_clk) && bit_clk) |-> samp_en);

    assert_aux_high_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        aux_clk |-> (32'(hi_run) < MAXHI));

    assert_reset_state_R9: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (!bit_clk && !samp_en && !sym_en && aux_clk));
endmodule

bind mod_clkgen mcg_checker #(.ADIV_W(ADIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .samp_en (samp_en),
    .sym_en  (sym_en),
    .bit_clk (bit_clk),
    .aux_clk (aux_clk)
);

// File: tb/mod_clkgen_tb.sv
module mod_clkgen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       ext_mode = 1'b0;
    logic       ext_dclk = 1'b0;
    logic [7:0] samp_div = 8'd4;
    logic [3:0] aux_div = 4'd2;
    logic       samp_en, sym_en, bit_clk, aux_clk;

    int    checks = 0;
    int    fails = 0;
    string ctx = "R9 reset";
    bit    done = 1'b0;

    int m_left, m_q, m_apos, m_alim;
    bit m_samp, m_sym, m_bit, m_aux, m_armed, m_pen, m_pd;

    mod_clkgen u_dut (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .ext_mode (ext_mode),
        .ext_dclk (ext_dclk),
        .samp_div (samp_div),
        .aux_div  (aux_div),
        .samp_en  (samp_en),
        .sym_en   (sym_en),
        .bit_clk  (bit_clk),
        .aux_clk  (aux_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_samp(input int v);
        return (v < 4) ? 4 : v;
    endfunction

    function automatic int eff_aux(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic chk(input string req, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual=%0d expected=%0d at %0t", req, ctx, name, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements.
    always @(posedge clk) begin
        automatic bit rise = ext_dclk && !m_pd;
        automatic bit arm  = ext_mode && clk_en && !m_pen;
        automatic bit fire;
        if (rst) begin
            m_left = 0; m_q = 0;
            m_samp = 0; m_sym = 0; m_bit = 0;
            m_apos = 0; m_alim = eff_aux(int'(aux_div)); m_aux = 1;
            m_armed = 0; m_pen = 0; m_pd = 0;
        end else begin
            m_samp = 0;
            m_sym  = 0;
            fire   = m_armed && clk_en && rise;
            if (fire) begin
                m_samp = 1; m_sym = 1; m_bit = 1; m_q = 1;
                m_left = eff_samp(int'(samp_div));
            end else if (m_armed) begin
                m_bit = 0;
            end else if (clk_en) begin
                if (m_left == 0) begin
                    m_samp = 1;
                    m_sym  = (m_q == 0);
                    m_bit  = !m_bit;
                    m_q    = (m_q + 1) % 4;
                    m_left = eff_samp(int'(samp_div));
                end else begin
                    m_left = m_left - 1;
                end
            end
            if (arm) m_armed = 1;
            else if (fire) m_armed = 0;
            if (m_apos == m_alim) begin
                m_apos = 0;
                m_alim = eff_aux(int'(aux_div));
            end else begin
                m_apos = m_apos + 1;
            end
            m_aux = (m_apos < (m_alim + 2) / 2);
            m_pen = clk_en;
            m_pd  = ext_dclk;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1", "samp_en", int'(samp_en), int'(m_samp));
            chk("R3", "sym_en",  int'(sym_en),  int'(m_sym));
            chk("R4", "bit_clk", int'(bit_clk), int'(m_bit));
            chk("R2", "aux_clk", int'(aux_clk), int'(m_aux));
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        clk_en = 1'b1;
        run(3);
        // R9: reset values while reset is held
        chk("R9", "samp_en", int'(samp_en), 0);
        chk("R9", "sym_en",  int'(sym_en),  0);
        chk("R9", "bit_clk", int'(bit_clk), 0);
        chk("R9", "aux_clk", int'(aux_clk), 1);
        rst = 1'b0;
        @(negedge clk);
        // R9: first enabled cycle after reset gives a sample and symbol pulse
        chk("R9", "first samp_en", int'(samp_en), 1);
        chk("R9", "first sym_en",  int'(sym_en),  1);

        ctx = "R1 R4 base";
        run(60);

        ctx = "R6 clamp";
        samp_div = 8'd1;
        aux_div  = 4'd0;
        run(60);

        ctx = "R7 change";
        samp_div = 8'd9;
        aux_div  = 4'd7;
        run(37);
        samp_div = 8'd5;
        aux_div  = 4'd3;
        run(41);
        aux_div = 4'd15;
        samp_div = 8'd255;
        run(300);
        samp_div = 8'd6;
        run(300);

        ctx = "R5 gate";
        clk_en = 1'b0;
        run(33);
        clk_en = 1'b1;
        run(29);
        clk_en = 1'b0;
        run(7);
        clk_en = 1'b1;
        run(20);

        ctx = "R8 ext";
        ext_mode = 1'b1;
        clk_en = 1'b0;
        run(5);
        clk_en = 1'b1;
        run(12);
        chk("R8", "bit_clk held low", int'(bit_clk), 0);
        ext_dclk = 1'b1;
        @(negedge clk);
        chk("R8", "resync samp_en", int'(samp_en), 1);
        chk("R8", "resync sym_en",  int'(sym_en),  1);
        chk("R8", "resync bit_clk", int'(bit_clk), 1);
        run(10);
        ext_dclk = 1'b0;
        run(3);
        ext_dclk = 1'b1;
        run(30);
        ext_dclk = 1'b0;
        ext_mode = 1'b0;
        run(10);

        ctx = "random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 199) == 0) samp_div = 8'($urandom_range(0, 12));
            if ($urandom_range(0, 99) == 0)  aux_div  = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 49) == 0)  clk_en   = ~clk_en;
            if ($urandom_range(0, 299) == 0) ext_mode = ~ext_mode;
            if ($urandom_range(0, 7) == 0)   ext_dclk = ~ext_dclk;
            @(negedge clk);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule